// File: doc/BRIEF.md
# Register Block Transfer Sequencer

This block moves a run of byte variables between a sixteen-entry variable file and a byte-wide synchronous memory. One start pulse carries a direction (store the variables to memory, or load them from memory), a last-variable number X and a 12-bit index address. The sequencer then walks the variables upward from variable 0 through variable X, both included, so at least one variable always moves. Each variable uses the address currently held in the index, and the index steps by one after every byte.

The pacing is fixed. A 14-cycle setup phase comes first, then one 14-cycle slot for each variable, and the timing is the same in both directions. When the last slot ends, the block raises a one-cycle done pulse and presents the advanced index, which points one past the last byte touched. The surrounding control logic writes that value back as the new index. The block does not check the address range: the index simply wraps within 12 bits.

Top module: `rbx_seq`

## Requirements
- R1: Variables are transferred in ascending order, variable 0 first and variable X last (X included), exactly one memory access per variable and no other access.
- R2: In store mode (`dir_load` = 0), slot k raises `mem_we` for one cycle with `mem_addr` = start index + k and `mem_wdata` = the value of variable k, read through `vf_sel`/`vf_rdata`.
- R3: In load mode (`dir_load` = 1), slot k presents address start index + k, and the byte the memory returns one cycle later is written into variable k through `vf_we`/`vf_sel`/`vf_wdata`.
- R4: The index increments modulo 4096. When done is pulsed, `idx_out` equals (start index + X + 1) mod 4096 and is not restored to its start value.
- R5: Done is pulsed exactly 14*(X+2) clock edges after the edge that accepts start: 28 for X = 0 and 238 for X = 15. Load and store take the same time.
- R6: `busy` is high from the cycle after an accepted start until the done cycle, in which `busy` is low. `done` lasts one cycle. A start pulse while `busy` is high is ignored: direction, X and the index of the running transfer are unchanged.
- R7: After reset, `busy`, `done`, `mem_we` and `vf_we` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, accepted only while idle |
| dir_load | input | 1 | 0 = store variables to memory, 1 = load variables from memory |
| x_last | input | 4 | Number of the last variable to transfer |
| idx_in | input | 12 | Start index address |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| idx_out | output | 12 | Running index; the advanced index when done is high |
| mem_addr | output | 12 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 8 | Memory read data, registered one cycle after the address |
| vf_sel | output | 4 | Variable file entry select |
| vf_wdata | output | 8 | Variable file write data |
| vf_we | output | 1 | Variable file write enable |
| vf_rdata | input | 8 | Variable file read data for the selected entry (combinational) |

## Verification
If the slot counter or the variable counter goes wrong, the scoreboard sees a memory write or a variable write at the wrong address or in the wrong order in the very slot where the fault occurs. A timing fault cannot stay hidden either, because the done pulse is checked against the exact edge count. An index that drifts or wraps wrongly shows on the very next access address and again in `idx_out` at done. A start pulse that slips through while busy either produces an extra access, which the scoreboard flags as unexpected, or moves the done pulse, so the fault shows within the transfer in which it happens.

// File: rtl/rbx_pkg.sv
package rbx_pkg;

    localparam int unsigned SETUP_CYCLES_DEF = 14;
    localparam int unsigned SLOT_CYCLES_DEF  = 14;
    localparam int unsigned ADDR_W_DEF       = 12;
    localparam int unsigned DATA_W_DEF       = 8;
    localparam int unsigned VAR_W            = 4;

    typedef enum logic {
        DIR_STORE = 1'b0,
        DIR_LOAD  = 1'b1
    } xdir_e;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SETUP = 2'd1,
        PH_SLOT  = 2'd2
    } phase_e;

    typedef struct packed {
        xdir_e            dir;
        logic [VAR_W-1:0] last;
    } req_t;

    function automatic int unsigned span_cycles(int unsigned setup, int unsigned slot,
                                                int unsigned nvar);
        return setup + slot * nvar;
    endfunction

    function automatic int unsigned cnt_width(int unsigned a, int unsigned b);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m < 2) ? 1 : $clog2(m);
    endfunction

endpackage

// File: rtl/rbx_pacer.sv
module rbx_pacer
    import rbx_pkg::*;
#(
    parameter int unsigned SETUP_CYC = SETUP_CYCLES_DEF,
    parameter int unsigned SLOT_CYC  = SLOT_CYCLES_DEF,
    localparam int unsigned CW       = cnt_width(SETUP_CYC, SLOT_CYC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [VAR_W-1:0] last_var,
    output phase_e           phase,
    output logic [CW-1:0]    cnt,
    output logic [VAR_W-1:0] var_idx,
    output logic             slot_end,
    output logic             busy,
    output logic             done
);

    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] SLOT_LAST  = CW'(SLOT_CYC - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            var_idx <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (phase)
                PH_IDLE: begin
                    if (go) begin
                        phase   <= PH_SETUP;
                        cnt     <= '0;
                        var_idx <= '0;
                    end
                end
                PH_SETUP: begin
                    if (cnt == SETUP_LAST) begin
                        phase <= PH_SLOT;
                        cnt   <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_SLOT: begin
                    if (cnt == SLOT_LAST) begin
                        cnt <= '0;
                        if (var_idx == last_var) begin
                            phase <= PH_IDLE;
                            done  <= 1'b1;
                        end else begin
                            var_idx <= var_idx + 1'b1;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign busy     = (phase != PH_IDLE);
    assign slot_end = (phase == PH_SLOT) && (cnt == SLOT_LAST);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R5
    slot_cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SLOT) |-> (cnt <= SLOT_LAST));

    // R1
    var_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_SLOT) |-> (var_idx <= last_var));

endmodule

// File: rtl/rbx_index.sv
module rbx_index #(
    parameter int unsigned AW = rbx_pkg::ADDR_W_DEF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] idx
);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (load) begin
            idx <= load_val;
        end else if (step) begin
            idx <= idx + 1'b1;
        end
    end

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(step) && !$past(load)) |-> (idx == AW'($past(idx) + 1'b1)));

endmodule

// File: rtl/rbx_port.sv
module rbx_port
    import rbx_pkg::*;
#(
    parameter int unsigned AW = ADDR_W_DEF,
    parameter int unsigned DW = DATA_W_DEF,
    parameter int unsigned CW = 4
) (
    input  phase_e           phase,
    input  logic [CW-1:0]    cnt,
    input  xdir_e            dir,
    input  logic [VAR_W-1:0] var_idx,
    input  logic [AW-1:0]    idx,
    input  logic [DW-1:0]    vf_rdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             mem_we,
    output logic [VAR_W-1:0] vf_sel,
    output logic [DW-1:0]    vf_wdata,
    output logic             vf_we
);

    localparam logic [CW-1:0] ACCESS_CYC  = '0;
    localparam logic [CW-1:0] CAPTURE_CYC = CW'(1);

    logic in_slot;

    always_comb begin
        in_slot   = (phase == PH_SLOT);
        mem_addr  = idx;
        vf_sel    = var_idx;
        mem_we    = in_slot && (dir == DIR_STORE) && (cnt == ACCESS_CYC);
        mem_wdata = mem_we ? vf_rdata : '0;
        vf_we     = in_slot && (dir == DIR_LOAD) && (cnt == CAPTURE_CYC);
        vf_wdata  = vf_we ? mem_rdata : '0;
    end

endmodule

// File: rtl/rbx_seq.sv
module rbx_seq
    import rbx_pkg::*;
#(
    parameter int unsigned ADDR_W    = ADDR_W_DEF,
    parameter int unsigned DATA_W    = DATA_W_DEF,
    parameter int unsigned SETUP_CYC = SETUP_CYCLES_DEF,
    parameter int unsigned SLOT_CYC  = SLOT_CYCLES_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              dir_load,
    input  logic [VAR_W-1:0]  x_last,
    input  logic [ADDR_W-1:0] idx_in,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] idx_out,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [VAR_W-1:0]  vf_sel,
    output logic [DATA_W-1:0] vf_wdata,
    output logic              vf_we,
    input  logic [DATA_W-1:0] vf_rdata
);

    localparam int unsigned CW      = cnt_width(SETUP_CYC, SLOT_CYC);
    localparam int unsigned MAX_RUN = span_cycles(SETUP_CYC, SLOT_CYC, 2 ** VAR_W);
    localparam int unsigned RW      = $clog2(MAX_RUN + 2);

    req_t             req_q;
    logic             accept;
    phase_e           phase;
    logic [CW-1:0]    cnt;
    logic [VAR_W-1:0] var_idx;
    logic             slot_end;
    logic [ADDR_W-1:0] idx;

    assign accept = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '{dir: DIR_STORE, last: '0};
        end else if (accept) begin
            req_q.dir  <= dir_load ? DIR_LOAD : DIR_STORE;
            req_q.last <= x_last;
        end
    end

    rbx_pacer #(
        .SETUP_CYC (SETUP_CYC),
        .SLOT_CYC  (SLOT_CYC)
    ) u_pacer (
        .clk      (clk),
        .rst      (rst),
        .go       (accept),
        .last_var (req_q.last),
        .phase    (phase),
        .cnt      (cnt),
        .var_idx  (var_idx),
        .slot_end (slot_end),
        .busy     (busy),
        .done     (done)
    );

    rbx_index #(
        .AW (ADDR_W)
    ) u_index (
        .clk      (clk),
        .rst      (rst),
        .load     (accept),
        .load_val (idx_in),
        .step     (slot_end),
        .idx      (idx)
    );

    rbx_port #(
        .AW (ADDR_W),
        .DW (DATA_W),
        .CW (CW)
    ) u_port (
        .phase     (phase),
        .cnt       (cnt),
        .dir       (req_q.dir),
        .var_idx   (var_idx),
        .idx       (idx),
        .vf_rdata  (vf_rdata),
        .mem_rdata (mem_rdata),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .vf_sel    (vf_sel),
        .vf_wdata  (vf_wdata),
        .vf_we     (vf_we)
    );

    assign idx_out = idx;

    logic [RW-1:0] run_cnt;
    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else              run_cnt <= run_cnt + 1'b1;
    end

    // R5
    run_len_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < RW'(MAX_RUN)));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(req_q));

    // R2
    store_only_chk: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (busy && !vf_we && req_q.dir == DIR_STORE));

    // R3
    load_only_chk: assert property (@(posedge clk) disable iff (rst)
        vf_we |-> (busy && req_q.dir == DIR_LOAD && $stable(mem_addr)));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mem_we && !vf_we));

endmodule

// File: tb/tb_rbx_seq.sv
module tb_rbx_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        dir_load = 1'b0;
    logic [3:0]  x_last = '0;
    logic [11:0] idx_in = '0;
    logic        busy, done, mem_we, vf_we;
    logic [11:0] idx_out, mem_addr;
    logic [7:0]  mem_wdata, vf_wdata, vf_rdata;
    logic [7:0]  mem_rdata = '0;
    logic [3:0]  vf_sel;

    always #2.5 clk = ~clk;

    rbx_seq dut (
        .clk(clk), .rst(rst), .start(start), .dir_load(dir_load), .x_last(x_last),
        .idx_in(idx_in), .busy(busy), .done(done), .idx_out(idx_out),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .vf_sel(vf_sel), .vf_wdata(vf_wdata), .vf_we(vf_we), .vf_rdata(vf_rdata)
    );

    logic [7:0] mem [4096];
    logic [7:0] vars [16];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        mem_rdata <= mem[mem_addr];
        if (vf_we) vars[vf_sel] <= vf_wdata;
    end
    assign vf_rdata = vars[vf_sel];

    typedef struct {
        int kind;   // 0 memory write, 1 variable write, 2 done
        int a;
        int d;
        string req;
    } item_t;

    item_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int t0 = 0;
    bit finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(string req, string what, int act, int expv);
        n_cmp++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic pop_cmp(int kind, int a, int d, string what);
        item_t it;
        if (exp_q.size() == 0) begin
            chk("R1", {"unexpected ", what}, kind, -1);
        end else begin
            it = exp_q.pop_front();
            chk(it.req, {what, " kind"}, kind, it.kind);
            chk(it.req, {what, " addr/sel/idx"}, a, it.a);
            chk(it.kind == 2 ? "R5" : it.req, {what, " data/cycles"}, d, it.d);
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_we) pop_cmp(0, int'(mem_addr), int'(mem_wdata), "mem write");
            if (vf_we)  pop_cmp(1, int'(vf_sel), int'(vf_wdata), "var write");
            if (done) begin
                chk("R6", "busy at done", int'(busy), 0);
                pop_cmp(2, int'(idx_out), cyc - t0, "done");
            end
        end
    end

    // driver
    task automatic run_op(bit ld, int x, int i0, bit poke);
        for (int k = 0; k <= x; k++) begin
            int a;
            a = (i0 + k) % 4096;
            if (!ld) exp_q.push_back('{0, a, int'(vars[k]), "R2"});
            else     exp_q.push_back('{1, k, int'(mem[a]), "R3"});
        end
        // R4 final index, R5 duration
        exp_q.push_back('{2, (i0 + x + 1) % 4096, 14 * (x + 2), "R4"});
        @(negedge clk);
        start = 1'b1; dir_load = ld; x_last = 4'(x); idx_in = 12'(i0);
        t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        chk("R6", "busy after start", int'(busy), 1);
        if (poke) begin
            repeat (20) @(negedge clk);
            start = 1'b1; dir_load = ~ld; x_last = 4'(x) ^ 4'hF; idx_in = 12'h555;
            @(negedge clk);
            start = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk("R6", "done one cycle", int'(done), 0);
        chk("R6", "busy after done", int'(busy), 0);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 7 + 3) ^ (a >> 4));
        for (int k = 0; k < 16; k++) vars[k] = 8'(8'hA0 + k * 5);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7 reset state
        chk("R7", "busy", int'(busy), 0);
        chk("R7", "done", int'(done), 0);
        chk("R7", "mem_we", int'(mem_we), 0);
        chk("R7", "vf_we", int'(vf_we), 0);

        run_op(1'b0, 0, 12'h100, 1'b0);   // R1 minimal store, R5 28 cycles
        run_op(1'b0, 15, 12'h200, 1'b0);  // R2 full store, R5 238 cycles
        run_op(1'b1, 7, 12'h010, 1'b0);   // R3 load
        run_op(1'b0, 3, 12'hFFE, 1'b0);   // R4 wrap during store
        run_op(1'b1, 15, 12'hFF8, 1'b1);  // R3 R4 wrap load, R6 start ignored
        run_op(1'b1, 0, 12'h1FF, 1'b0);   // R5 load timing equals store timing

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule